// File: doc/BRIEF.md
# Fixed-Slice Window Address Decoder

This block decides whether a host address belongs to the downstream memory-mapped space. The top 256 MB of a 32-bit address map (addresses 0xF000_0000 to 0xFFFF_FFFF) is cut into 32 equal slices of 8 MB. A 32-bit enable mask picks which slices are forwarded: bit k of the mask opens the slice that starts at 0xF000_0000 + k * 0x0080_0000. Setting several neighbouring bits yields one unbroken decoded range.

The mask lives in one register that software writes and reads through a small register port at offset 0x060. The lookup side is purely combinational. An address goes in and a hit flag comes out, together with the slice number. While the mask is zero, no memory-mapped access is claimed. Port-space traffic does not pass through this decoder, so a zero mask leaves it untouched.

Top module: `slice_window_decoder`

## Requirements
- R1: After reset the enable mask is zero: a read of offset 0x060 returns 0 and no address hits.
- R2: A write (`cfg_we` high at a rising edge) to offset 0x060 loads `cfg_wdata` into the mask. A read of offset 0x060 (`cfg_addr` = 0x060) returns the mask combinationally.
- R3: A write to any offset other than 0x060 leaves the mask unchanged. A read of any other offset returns 0.
- R4: `lkp_hit` is 1 exactly when `lkp_addr[31:28]` = 4'hF and mask bit `lkp_addr[27:23]` is 1.
- R5: An address whose bits 31:28 are not 4'hF never hits, whatever the mask holds.
- R6: While the mask is zero, no address hits.
- R7: `lkp_win` always equals `lkp_addr[27:23]`, the slice number.
- R8: Neighbouring enabled bits decode as one range. Every address from the first byte of the lowest enabled slice to the last byte of the highest one hits, including both sides of each internal slice boundary. The byte just past either end misses when the slice beyond is disabled.
- R9: A mask write takes effect one cycle later. During the cycle of the write, lookups still use the old mask; right after that rising edge they use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register offset for write and read |
| cfg_wdata | input | 32 | Write data for the enable mask |
| cfg_rdata | output | 32 | Read data (mask at 0x060, else 0) |
| lkp_addr | input | 32 | Host address to decode |
| lkp_hit | output | 1 | Address falls in an enabled slice |
| lkp_win | output | 5 | Slice number of the address |

## Verification
The lookup outputs and the register read data are combinational, so they are due in the same cycle as the address or offset that produces them. The bench sets inputs after a falling edge and samples one nanosecond later, with no clock edge in between. A mask write is due one rising edge after the strobe is presented. The bench therefore checks lookups once before that edge, expecting the old mask, and once after the following falling edge, expecting the new mask. Expected values come from bench functions applied to a bench copy of the mask that is updated only by the bench's own writes.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int unsigned SWD_ADDR_W    = 32;
  localparam int unsigned SWD_NUM_WIN   = 32;
  localparam int unsigned SWD_WIN_SHIFT = 23;
  localparam int unsigned SWD_CSR_AW    = 12;
  localparam logic [11:0] SWD_MASK_OFF  = 12'h060;
  localparam logic [31:0] SWD_REGION    = 32'hF000_0000;
endpackage

// File: rtl/win_mask_reg.sv
module win_mask_reg #(
  parameter int unsigned NUM_WIN = 32,
  parameter int unsigned CSR_AW  = 12,
  parameter logic [CSR_AW-1:0] MASK_OFF = 12'h060
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CSR_AW-1:0]  addr,
  input  logic [NUM_WIN-1:0] wdata,
  output logic [NUM_WIN-1:0] mask_q,
  output logic [NUM_WIN-1:0] rdata
);
  logic sel;
  logic load;

  assign sel  = (addr == MASK_OFF);
  assign load = we && sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (load) mask_q <= wdata;
  end

  assign rdata = sel ? mask_q : '0;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mask_q == $past(wdata)));  // R2
  AST_OTHER_OFFSET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mask_q));  // R3
endmodule

// File: rtl/win_index_calc.sv
module win_index_calc #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_SHIFT = 23,
  parameter int unsigned IDX_W     = 5,
  parameter logic [ADDR_W-1:0] REGION = 32'hF000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_region,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned TOP = WIN_SHIFT + IDX_W;

  function automatic logic region_match(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:TOP] == REGION[ADDR_W-1:TOP];
  endfunction

  function automatic logic [IDX_W-1:0] slice_of(input logic [ADDR_W-1:0] a);
    return a[TOP-1:WIN_SHIFT];
  endfunction

  assign in_region = region_match(addr);
  assign idx       = slice_of(addr);
endmodule

// File: rtl/win_hit_logic.sv
module win_hit_logic #(
  parameter int unsigned NUM_WIN = 32,
  parameter int unsigned IDX_W   = 5
) (
  input  logic               in_region,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_WIN-1:0] mask,
  output logic               hit
);
  logic slice_on;

  generate
    if (NUM_WIN == (1 << IDX_W)) begin : g_full
      assign slice_on = mask[idx];
    end else begin : g_partial
      assign slice_on = (32'(idx) < NUM_WIN) ? mask[idx] : 1'b0;
    end
  endgenerate

  assign hit = in_region && slice_on;
endmodule

// File: rtl/slice_window_decoder.sv
module slice_window_decoder
  import swd_pkg::*;
#(
  parameter int unsigned ADDR_W    = SWD_ADDR_W,
  parameter int unsigned NUM_WIN   = SWD_NUM_WIN,
  parameter int unsigned WIN_SHIFT = SWD_WIN_SHIFT,
  parameter int unsigned CSR_AW    = SWD_CSR_AW,
  parameter logic [CSR_AW-1:0] MASK_OFF = SWD_MASK_OFF,
  parameter logic [ADDR_W-1:0] REGION   = SWD_REGION
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CSR_AW-1:0]  cfg_addr,
  input  logic [NUM_WIN-1:0] cfg_wdata,
  output logic [NUM_WIN-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0]  lkp_addr,
  output logic               lkp_hit,
  output logic [$clog2(NUM_WIN)-1:0] lkp_win
);
  localparam int unsigned IDX_W = $clog2(NUM_WIN);
  localparam int unsigned TOP   = WIN_SHIFT + IDX_W;

  logic [NUM_WIN-1:0] mask_q;
  logic               in_region;
  logic [IDX_W-1:0]   idx;
  logic               hit;

  win_mask_reg #(.NUM_WIN(NUM_WIN), .CSR_AW(CSR_AW), .MASK_OFF(MASK_OFF)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .mask_q(mask_q), .rdata(cfg_rdata)
  );

  win_index_calc #(.ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .IDX_W(IDX_W), .REGION(REGION)) u_idx (
    .addr(lkp_addr), .in_region(in_region), .idx(idx)
  );

  win_hit_logic #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_hit (
    .in_region(in_region), .idx(idx), .mask(mask_q), .hit(hit)
  );

  assign lkp_hit = hit;
  assign lkp_win = idx;

  AST_OUTSIDE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_addr[ADDR_W-1:TOP] != REGION[ADDR_W-1:TOP]) |-> !lkp_hit);  // R5
  AST_ZERO_MASK_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !lkp_hit);  // R6
  AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit |-> ($countones(mask_q) > 0) && in_region);  // R4
  AST_WIN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_win == lkp_addr[TOP-1:WIN_SHIFT]);  // R7
endmodule

// File: tb/slice_window_decoder_test.sv
module slice_window_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = 12'h000;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] lkp_addr = '0;
  logic        lkp_hit;
  logic [4:0]  lkp_win;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model_mask = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  slice_window_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lkp_addr(lkp_addr),
    .lkp_hit(lkp_hit), .lkp_win(lkp_win)
  );

  function automatic logic want_hit(input logic [31:0] m, input logic [31:0] a);
    int slice;
    slice = int'((a - 32'hF000_0000) / 32'h0080_0000);
    if (a < 32'hF000_0000) return 1'b0;
    return m[slice];
  endfunction

  function automatic logic [4:0] want_win(input logic [31:0] a);
    return 5'((a % 32'h1000_0000) / 32'h0080_0000);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic look(input string req, input logic [31:0] a);
    @(negedge clk);
    lkp_addr = a;
    #1;
    check(req, 32'(lkp_hit), 32'(want_hit(model_mask, a)));
    check("R7", 32'(lkp_win), 32'(want_win(a)));
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (off == 12'h060) model_mask = d;
  endtask

  task automatic rd(input string req, input logic [11:0] off);
    @(negedge clk);
    cfg_addr = off;
    #1;
    check(req, cfg_rdata, (off == 12'h060) ? model_mask : 32'h0);
  endtask

  initial begin
    int unsigned seed;
    logic [31:0] a;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd("R1", 12'h060);
    look("R1", 32'hF000_0000);
    look("R1", 32'hFFFF_FFFF);
    // R6: zero mask, random in-region addresses
    for (int i = 0; i < 20; i++) look("R6", 32'hF000_0000 | ($urandom() & 32'h0FFF_FFFF));
    // R2: write and read back
    wr(12'h060, 32'h0000_0001);
    rd("R2", 12'h060);
    look("R4", 32'hF000_0000);
    look("R4", 32'hF07F_FFFF);
    look("R4", 32'hF080_0000);
    // R3: other offsets ignored, read as zero
    wr(12'h064, 32'hFFFF_FFFF);
    rd("R3", 12'h060);
    rd("R3", 12'h064);
    look("R3", 32'hF080_0000);
    wr(12'h860, 32'hFFFF_FFFF);
    rd("R3", 12'h060);
    // R5: outside region with full mask
    wr(12'h060, 32'hFFFF_FFFF);
    look("R5", 32'hEFFF_FFFF);
    look("R5", 32'h7000_0000);
    look("R5", 32'h0000_0000);
    look("R4", 32'hFFFF_FFFF);
    // R8: contiguous slices 3..6
    wr(12'h060, 32'h0000_0078);
    look("R8", 32'hF17F_FFFF);
    look("R8", 32'hF180_0000);
    look("R8", 32'hF1FF_FFFF);
    look("R8", 32'hF200_0000);
    look("R8", 32'hF37F_FFFF);
    look("R8", 32'hF380_0000);
    // R9: same-cycle lookup sees old mask, next cycle sees new
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 12'h060; cfg_wdata = 32'h8000_0000;
    lkp_addr = 32'hFF80_0000;
    #1;
    check("R9", 32'(lkp_hit), 32'd0);
    @(negedge clk);
    cfg_we = 1'b0;
    model_mask = 32'h8000_0000;
    #1;
    check("R9", 32'(lkp_hit), 32'd1);
    // R4: random masks and addresses
    for (int i = 0; i < 40; i++) begin
      wr(12'h060, $urandom());
      rd("R2", 12'h060);
      for (int j = 0; j < 8; j++) begin
        a = $urandom();
        if (j < 6) a[31:28] = 4'hF;
        look("R4", a);
      end
    end
    // back to zero
    wr(12'h060, 32'h0);
    look("R6", 32'hF400_0000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule